// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from power-up to a usable state without any software help. After reset it keeps the clock-enable pin low for a programmable settling period. It then raises clock-enable, waits a short hold time, and plays a fixed list of seven commands to the device. Between commands it drives NOP for a minimum number of controller cycles. When the list is finished it raises `init_done`, and the memory controller can take over the command pins.

Each command is presented on separate pins: a 3-bit command code for the RAS/CAS/WE lines, the bank address, the row address and clock-enable. The same command also appears as one packed word for a downstream command queue. A build-time parameter selects whether the device DLL is left on or turned off. A second build-time parameter adds one spare NOP after each wait, giving extra timing margin. The wait lengths are parameters in cycles; the defaults suit a 100 MHz controller clock.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and immediately when it falls (asynchronously), the outputs are: `ddr_cke`=0, `ddr_cmd`=NOP, `ddr_ba`=0, `ddr_addr`=0, `init_done`=0. After `rst_n` rises again, the whole sequence restarts from the power-up wait.
- R2: Counting the cycle in which `rst_n` is first seen high as cycle 0, `ddr_cke` is 0 and `ddr_cmd` is NOP for exactly PWRUP_CYC cycles.
- R3: `ddr_cke` then goes to 1 and stays 1 until the next reset. NOP is held for CKE_HOLD_CYC further cycles before the first command.
- R4: The seven commands are issued in this order, each with bank and row shown as (bank, row):
  - PRECHARGE with row 0x400 (A10, all banks), bank 0.
  - Extended mode load, bank 1.
  - Mode load, row 0x121 (DLL reset, CAS latency 2, burst 2), bank 0.
  - PRECHARGE, row 0x400, bank 0.
  - AUTO REFRESH, bank 0, row 0.
  - AUTO REFRESH, bank 0, row 0.
  - Mode load, row 0x021, bank 0.
- R5: The command codes are: mode/extended-mode load 3'b000, AUTO REFRESH 3'b001, PRECHARGE 3'b010, NOP 3'b111. Each command lasts exactly one cycle. Bank and row are 0 whenever NOP is driven.
- R6: The extended mode value is row 0x000 when DLL_OFF=0 and row 0x001 when DLL_OFF=1.
- R7: After each command, NOP is driven for exactly the wait that matches the command: T_RP_CYC after PRECHARGE, T_MRD_CYC after a mode load, T_RFC_CYC after AUTO REFRESH. The defaults are 2, 2 and 8 cycles.
- R8: With EXTRA_NOP=1, exactly one more NOP cycle follows each wait, except the wait after the last command. With EXTRA_NOP=0 there is none.
- R9: `init_done` first goes high in the cycle after the wait that follows the last mode load. It then stays high with NOP and `ddr_cke`=1 until reset.
- R10: `cmd_word` packs the row at bits ROW_W+12:13, the bank at bits 12:11 and the command code at bits 6:4. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_cke | output | 1 | Device clock-enable |
| ddr_cmd | output | 3 | RAS/CAS/WE command code |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | ROW_W | Row address / mode value |
| cmd_word | output | ROW_W+13 | Packed row, bank and command |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds two copies at once. The first has a 5-cycle power-up wait, a 1-cycle clock-enable hold, DLL on and no spare NOPs. The second has a 3-cycle power-up wait, a 2-cycle hold, DLL off, spare NOPs, and unequal wait lengths of 3, 2 and 5 cycles. With these short settings the whole sequence, and the cycles after completion, fit in a cycle-by-cycle sweep. In that sweep every output field of both copies is compared against a reference that works out the phase of each cycle by arithmetic. A reset applied partway through the sequence, followed by a second full sweep, covers the restart path.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = 3;
  localparam int BANK_W    = 2;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_CKE,
    ST_CMD,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/ddr_seq_steps.sv
module ddr_seq_steps
  import ddr_seq_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int CNT_W     = 16,
  parameter bit DLL_OFF   = 1'b0,
  parameter int T_RP_CYC  = 2,
  parameter int T_MRD_CYC = 2,
  parameter int T_RFC_CYC = 8
) (
  input  logic [STEP_W-1:0] step_idx,
  output logic [2:0]        step_cmd,
  output logic [BANK_W-1:0] step_ba,
  output logic [ROW_W-1:0]  step_row,
  output logic [CNT_W-1:0]  step_wait
);

  localparam logic [ROW_W-1:0] ROW_PRE_ALL = ROW_W'(16'h0400);
  localparam logic [ROW_W-1:0] ROW_EMR     = DLL_OFF ? ROW_W'(16'h0001) : ROW_W'(16'h0000);
  localparam logic [ROW_W-1:0] ROW_MR_RST  = ROW_W'(16'h0121);
  localparam logic [ROW_W-1:0] ROW_MR_RUN  = ROW_W'(16'h0021);

  always_comb begin
    step_ba  = '0;
    step_row = '0;
    case (step_idx)
      3'd0, 3'd3: begin
        step_cmd = CMD_PRE;
        step_row = ROW_PRE_ALL;
      end
      3'd1: begin
        step_cmd = CMD_LMR;
        step_ba  = BANK_W'(1);
        step_row = ROW_EMR;
      end
      3'd2: begin
        step_cmd = CMD_LMR;
        step_row = ROW_MR_RST;
      end
      3'd4, 3'd5: step_cmd = CMD_REF;
      3'd6: begin
        step_cmd = CMD_LMR;
        step_row = ROW_MR_RUN;
      end
      default: step_cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    case (step_cmd)
      CMD_PRE: step_wait = CNT_W'(T_RP_CYC);
      CMD_LMR: step_wait = CNT_W'(T_MRD_CYC);
      CMD_REF: step_wait = CNT_W'(T_RFC_CYC);
      default: step_wait = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/ddr_seq_timer.sv
module ddr_seq_timer #(
  parameter int CNT_W = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ddr_seq_ctrl.sv
module ddr_seq_ctrl
  import ddr_seq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int CKE_HOLD_CYC = 1,
  parameter bit EXTRA_NOP    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_expired,
  input  logic [CNT_W-1:0]  step_wait,
  output seq_state_e        state,
  output logic [STEP_W-1:0] step_idx,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_PWR: if (tmr_expired) begin
        state_d  = ST_CKE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CKE_HOLD_CYC - 1);
      end
      ST_CKE: if (tmr_expired) begin
        state_d = ST_CMD;
        step_d  = '0;
      end
      ST_CMD: begin
        state_d  = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = step_wait - 1'b1;
      end
      ST_WAIT: if (tmr_expired) begin
        if (step_q == LAST_STEP) begin
          state_d = ST_DONE;
        end else if (EXTRA_NOP) begin
          state_d = ST_GAP;
        end else begin
          state_d = ST_CMD;
          step_d  = step_q + 1'b1;
        end
      end
      ST_GAP: begin
        state_d = ST_CMD;
        step_d  = step_q + 1'b1;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign state    = state_q;
  assign step_idx = step_q;

endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq
  import ddr_seq_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int PWRUP_CYC    = 20000,
  parameter int CKE_HOLD_CYC = 1,
  parameter int T_RP_CYC     = 2,
  parameter int T_MRD_CYC    = 2,
  parameter int T_RFC_CYC    = 8,
  parameter bit DLL_OFF      = 1'b0,
  parameter bit EXTRA_NOP    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             ddr_cke,
  output logic [2:0]       ddr_cmd,
  output logic [1:0]       ddr_ba,
  output logic [ROW_W-1:0] ddr_addr,
  output logic [ROW_W+12:0] cmd_word,
  output logic             init_done
);

  localparam int CNT_W = $clog2(PWRUP_CYC + CKE_HOLD_CYC + T_RP_CYC + T_MRD_CYC + T_RFC_CYC + 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step_idx;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val, step_wait;
  logic [2:0]        step_cmd;
  logic [BANK_W-1:0] step_ba;
  logic [ROW_W-1:0]  step_row;
  logic              issue;

  ddr_seq_steps #(
    .ROW_W(ROW_W), .CNT_W(CNT_W), .DLL_OFF(DLL_OFF),
    .T_RP_CYC(T_RP_CYC), .T_MRD_CYC(T_MRD_CYC), .T_RFC_CYC(T_RFC_CYC)
  ) u_steps (
    .step_idx(step_idx), .step_cmd(step_cmd), .step_ba(step_ba),
    .step_row(step_row), .step_wait(step_wait)
  );

  ddr_seq_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  ddr_seq_ctrl #(
    .CNT_W(CNT_W), .CKE_HOLD_CYC(CKE_HOLD_CYC), .EXTRA_NOP(EXTRA_NOP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_expired(tmr_expired), .step_wait(step_wait),
    .state(state), .step_idx(step_idx), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  assign issue     = (state == ST_CMD);
  assign ddr_cke   = (state != ST_PWR);
  assign init_done = (state == ST_DONE);
  assign ddr_cmd   = issue ? step_cmd : CMD_NOP;
  assign ddr_ba    = issue ? step_ba  : '0;
  assign ddr_addr  = issue ? step_row : '0;
  assign cmd_word  = {ddr_addr, ddr_ba, 4'b0000, ddr_cmd, 4'b0000};

endmodule

// File: rtl/ddr_bringup_chk.sv
module ddr_bringup_chk #(
  parameter int ROW_W     = 13,
  parameter int T_RP_CYC  = 2,
  parameter int T_MRD_CYC = 2,
  parameter int T_RFC_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ddr_cke,
  input logic [2:0]       ddr_cmd,
  input logic [1:0]       ddr_ba,
  input logic [ROW_W-1:0] ddr_addr,
  input logic             init_done
);

  localparam logic [2:0] NOP = 3'b111;

  logic [15:0] gap_q;
  logic [2:0]  last_q;
  logic        seen_q;
  int          need;

  always_comb begin
    case (last_q)
      3'b010:  need = T_RP_CYC;
      3'b000:  need = T_MRD_CYC;
      3'b001:  need = T_RFC_CYC;
      default: need = 0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      last_q <= NOP;
      seen_q <= 1'b0;
    end else if (ddr_cmd != NOP) begin
      gap_q  <= '0;
      last_q <= ddr_cmd;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hffff) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> (ddr_cmd == NOP && !init_done)); // R2
  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |=> ddr_cke); // R3
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cmd inside {3'b000, 3'b001, 3'b010, 3'b111}); // R5
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd != NOP) |=> (ddr_cmd == NOP)); // R5
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd == NOP) |-> (ddr_ba == '0 && ddr_addr == '0)); // R5
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd != NOP && seen_q) |-> (int'(gap_q) >= need)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ddr_cmd == NOP && ddr_cke)); // R9
  AST_DONE_AFTER_RUN_MR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (seen_q && last_q == 3'b000)); // R9

endmodule

bind ddr_bringup_seq ddr_bringup_chk #(
  .ROW_W(ROW_W), .T_RP_CYC(T_RP_CYC), .T_MRD_CYC(T_MRD_CYC), .T_RFC_CYC(T_RFC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_cke(ddr_cke), .ddr_cmd(ddr_cmd),
  .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
);

// File: tb/test_ddr_bringup_seq.sv
`timescale 1ns/1ps
module test_ddr_bringup_seq;

  localparam int RW = 13;

  logic clk, rst_n;
  logic          a_cke, b_cke, a_done, b_done;
  logic [2:0]    a_cmd, b_cmd;
  logic [1:0]    a_ba, b_ba;
  logic [RW-1:0] a_addr, b_addr;
  logic [RW+12:0] a_word, b_word;

  int vectors = 0;
  int fails   = 0;

  ddr_bringup_seq #(.ROW_W(RW), .PWRUP_CYC(5), .CKE_HOLD_CYC(1), .T_RP_CYC(2),
    .T_MRD_CYC(2), .T_RFC_CYC(8), .DLL_OFF(1'b0), .EXTRA_NOP(1'b0)) i_ddr_bringup_seq (
    .clk(clk), .rst_n(rst_n), .ddr_cke(a_cke), .ddr_cmd(a_cmd), .ddr_ba(a_ba),
    .ddr_addr(a_addr), .cmd_word(a_word), .init_done(a_done));

  ddr_bringup_seq #(.ROW_W(RW), .PWRUP_CYC(3), .CKE_HOLD_CYC(2), .T_RP_CYC(3),
    .T_MRD_CYC(2), .T_RFC_CYC(5), .DLL_OFF(1'b1), .EXTRA_NOP(1'b1)) i_ddr_bringup_seq_b (
    .clk(clk), .rst_n(rst_n), .ddr_cke(b_cke), .ddr_cmd(b_cmd), .ddr_ba(b_ba),
    .ddr_addr(b_addr), .cmd_word(b_word), .init_done(b_done));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // command list from the requirements: code, bank, row
  function automatic int step_code(input int i);
    case (i)
      0, 3: return 2;
      4, 5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int step_row(input int i, input int dll_off);
    case (i)
      0, 3: return 'h400;
      1: return dll_off;
      2: return 'h121;
      6: return 'h021;
      default: return 0;
    endcase
  endfunction

  // expected outputs in cycle k after reset release
  task automatic model(input int k, input int p, input int h, input int rp,
                       input int mrd, input int rfc, input int dll, input int xtra,
                       output int cke, output int cmd, output int ba, output int row,
                       output int done, output string tag);
    int t, w;
    t = k; cke = 1; cmd = 7; ba = 0; row = 0; done = 0;
    if (t < p) begin cke = 0; tag = "R2"; return; end
    t -= p;
    if (t < h) begin tag = "R3"; return; end
    t -= h;
    for (int i = 0; i < 7; i++) begin
      if (t == 0) begin
        cmd = step_code(i); row = step_row(i, dll); ba = (i == 1) ? 1 : 0;
        tag = (i == 1) ? "R6" : "R4";
        return;
      end
      t -= 1;
      w = (step_code(i) == 2) ? rp : (step_code(i) == 0) ? mrd : rfc;
      if (t < w) begin tag = "R7"; return; end
      t -= w;
      if (xtra != 0 && i < 6) begin
        if (t == 0) begin tag = "R8"; return; end
        t -= 1;
      end
    end
    done = 1; tag = "R9";
  endtask

  task automatic check_cycle(input int k);
    int cke, cmd, ba, row, done;
    string tag;
    model(k, 5, 1, 2, 2, 8, 0, 0, cke, cmd, ba, row, done, tag);
    chk({tag, " A cke"}, a_cke, cke);
    chk({tag, " R5 A cmd"}, a_cmd, cmd);
    chk({tag, " A ba"}, a_ba, ba);
    chk({tag, " A row"}, a_addr, row);
    chk({tag, " R9 A done"}, a_done, done);
    chk("R10 A word", int'(a_word), (row << 13) | (ba << 11) | (cmd << 4));
    model(k, 3, 2, 3, 2, 5, 1, 1, cke, cmd, ba, row, done, tag);
    chk({tag, " B cke"}, b_cke, cke);
    chk({tag, " R5 B cmd"}, b_cmd, cmd);
    chk({tag, " B ba"}, b_ba, ba);
    chk({tag, " B row"}, b_addr, row);
    chk({tag, " R9 B done"}, b_done, done);
    chk("R10 B word", int'(b_word), (row << 13) | (ba << 11) | (cmd << 4));
  endtask

  task automatic check_reset();
    chk("R1 A cke", a_cke, 0);   chk("R1 B cke", b_cke, 0);
    chk("R1 A cmd", a_cmd, 7);   chk("R1 B cmd", b_cmd, 7);
    chk("R1 A row", a_addr, 0);  chk("R1 B row", b_addr, 0);
    chk("R1 A ba", a_ba, 0);     chk("R1 B ba", b_ba, 0);
    chk("R1 A done", a_done, 0); chk("R1 B done", b_done, 0);
  endtask

  task automatic sweep(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      #1 check_cycle(k);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    sweep(70);
    // restart partway through: R1
    rst_n = 1'b0;
    #1 check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    sweep(15);
    #0.5 rst_n = 1'b0;
    #0.5 check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    sweep(70);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule